// File: doc/BRIEF.md
# I2C Register Slave with High-Speed Mode Entry

This block is a synchronous I2C target that exposes a small bank of 8-bit control registers. A system clock much faster than SCL oversamples both bus lines through a two-flop synchronizer. Edge detection on the synchronized lines finds START and STOP conditions and SCL edges. The open-drain SDA driver appears as a single output enable: while `sdaOe` is high the pad pulls SDA low. SCL is never driven, because the block does not stretch the clock.

The 7-bit target address has a hardwired upper part `10010` and two low bits taken from strap pins, so four copies can share one bus. A write transfer uses its first data byte as the register pointer. Each later byte is stored at the pointer, which then advances. A read transfer returns bytes starting at the pointer, MSB first, and advances the pointer after each byte. It continues while the controller acknowledges. The high-speed controller code is recognized and never acknowledged. It raises a mode flag that survives repeated STARTs and clears on STOP.

Top module: `hs_i2c_regbank`

## Requirements
- R1: A falling SDA while SCL is high is a START and begins address reception. A rising SDA while SCL is high is a STOP: the block releases SDA (`sdaOe`=0) and ignores all traffic until the next START.
- R2: The target address is `{10010, strapAddr[1:0]}`, sent MSB first and followed by the R/W bit (0 = write, 1 = read). On a match the block holds SDA low during the entire high phase of the ninth SCL pulse. On any other address, including one that differs only in the strap bits, it never drives SDA in that transfer.
- R3: The general-call address (seven zero bits) is never acknowledged, and the data bytes that follow it have no effect on the registers.
- R4: A first byte after a START whose top five bits are `00001` is the high-speed controller code. It is not acknowledged, and it sets `hsMode`, which stays at 1 until a STOP clears it.
- R5: In a write transfer every data byte is acknowledged. The first data byte loads the register pointer. Each following byte is written to the register at the pointer, and the pointer then increments by one.
- R6: In a read transfer the block drives the byte at the pointer MSB first and increments the pointer after each byte. It sends the next byte when the controller acknowledges. After a not-acknowledge it releases SDA until a STOP or START.
- R7: Registers exist at pointer values 0 to NUM_REGS-1. Reading any other pointer value returns FFh, and writing one changes no register.
- R8: A repeated START (a START with no STOP before it) restarts address matching, keeps the register pointer, and leaves `hsMode` unchanged.
- R9: After reset all registers read 00h, `hsMode` is 0 and `sdaOe` is 0.

Top module port `regFlat` presents register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen at the pad |
| sdaIn | input | 1 | SDA level seen at the pad |
| strapAddr | input | 2 | Low two bits of the target address |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| hsMode | output | 1 | High-speed mode flag |
| regFlat | output | NUM_REGS*8 | Contents of all control registers |

## Verification
The bench checks the acknowledge over the whole high phase of the ninth pulse, not at one point in it. A design that releases SDA too early, or one that acknowledges the high-speed code or the general call, is caught there. It walks the pointer across the end of the map in both directions. A design that wraps the index or writes an alias would corrupt register 0 or return stale data instead of FFh. A repeated START follows both the pointer write and the high-speed code. A design that treats it as a STOP would lose `hsMode`, or it would not acknowledge the new address. After a not-acknowledge the bench adds an extra clock pulse, which exposes a design that keeps driving read data.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam logic [4:0] ADDR_PREFIX = 5'b10010;
  localparam logic [4:0] HS_CODE_TOP = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_WAIT
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic cntClr;
    logic txLoad;
    logic txShift;
    logic ptrLoad;
    logic ptrInc;
    logic regWrite;
    logic hsSet;
    logic hsClr;
  } dpCtrl_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctrl,
  input  logic                  sdaLvl,
  output logic [7:0]            rxByte,
  output logic [3:0]            bitCnt,
  output logic                  txBit,
  output logic                  hsMode,
  output logic [7:0]            ptr,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0]       regs [NUM_REGS];
  logic [7:0]       txReg;
  logic             mapped;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rdData;

  assign mapped = ({1'b0, ptr} < 9'(NUM_REGS));
  assign idx    = ptr[IDX_W-1:0];
  assign rdData = mapped ? regs[idx] : 8'hFF;
  assign txBit  = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
      txReg  <= 8'hFF;
      ptr    <= '0;
      hsMode <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (ctrl.shiftIn) rxByte <= {rxByte[6:0], sdaLvl};

      if (ctrl.cntClr) bitCnt <= '0;
      else if (ctrl.shiftIn || ctrl.txShift) bitCnt <= bitCnt + 4'd1;

      if (ctrl.txLoad) txReg <= rdData;
      else if (ctrl.txShift) txReg <= {txReg[6:0], 1'b1};

      if (ctrl.ptrLoad) ptr <= rxByte;
      else if (ctrl.ptrInc) ptr <= ptr + 8'd1;

      if (ctrl.regWrite && mapped) regs[idx] <= rxByte;

      if (ctrl.hsClr) hsMode <= 1'b0;
      else if (ctrl.hsSet) hsMode <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign regFlat[g*8 +: 8] = regs[g];
  end

endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaLvl,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic      txBit,
  input  logic [1:0] strapAddr,
  output dpCtrl_t   ctrl,
  output logic      sdaOe,
  output busState_t stateOut
);

  busState_t state, nxt;
  logic rwRead, rwNxt;
  logic firstData, firstNxt;
  logic ackOk, ackNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rwRead    <= 1'b0;
      firstData <= 1'b0;
      ackOk     <= 1'b0;
    end else begin
      state     <= nxt;
      rwRead    <= rwNxt;
      firstData <= firstNxt;
      ackOk     <= ackNxt;
    end
  end

  always_comb begin
    nxt      = state;
    ctrl     = '0;
    rwNxt    = rwRead;
    firstNxt = firstData;
    ackNxt   = ackOk;
    if (stopDet) begin
      nxt         = ST_IDLE;
      ctrl.hsClr  = 1'b1;
      ctrl.cntClr = 1'b1;
    end else if (startDet) begin
      nxt         = ST_ADDR;
      ctrl.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          ctrl.shiftIn = sclRise;
          if (sclFall && bitCnt == 4'd8) begin
            ctrl.cntClr = 1'b1;
            rwNxt       = rxByte[0];
            firstNxt    = 1'b1;
            if (rxByte[7:3] == HS_CODE_TOP) begin
              ctrl.hsSet = 1'b1;
              nxt        = ST_WAIT;
            end else if (rxByte[7:1] == {ADDR_PREFIX, strapAddr}) begin
              nxt = ST_ADDR_ACK;
            end else begin
              nxt = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctrl.cntClr = 1'b1;
            if (rwRead) begin
              ctrl.txLoad = 1'b1;
              nxt         = ST_RD_BYTE;
            end else begin
              nxt = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          ctrl.shiftIn = sclRise;
          if (sclFall && bitCnt == 4'd8) begin
            ctrl.cntClr = 1'b1;
            if (firstData) begin
              ctrl.ptrLoad = 1'b1;
              firstNxt     = 1'b0;
            end else begin
              ctrl.regWrite = 1'b1;
              ctrl.ptrInc   = 1'b1;
            end
            nxt = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) nxt = ST_WR_BYTE;
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              ctrl.cntClr = 1'b1;
              ctrl.ptrInc = 1'b1;
              nxt         = ST_RD_ACK;
            end else begin
              ctrl.txShift = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) ackNxt = ~sdaLvl;
          if (sclFall) begin
            if (ackOk) begin
              ctrl.txLoad = 1'b1;
              nxt         = ST_RD_BYTE;
            end else begin
              nxt = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_WR_ACK: sdaOe = 1'b1;
      ST_RD_BYTE:             sdaOe = ~txBit;
      default:                sdaOe = 1'b0;
    endcase
  end

  assign stateOut = state;

endmodule

// File: rtl/hs_i2c_regbank.sv
module hs_i2c_regbank
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [1:0]            strapAddr,
  output logic                  sdaOe,
  output logic                  hsMode,
  output logic [NUM_REGS*8-1:0] regFlat
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte, ptr;
  logic [3:0] bitCnt;
  logic txBit;
  dpCtrl_t dpCtrl;
  busState_t ctlState;

  i2cs_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cs_control uCtl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit), .strapAddr(strapAddr),
    .ctrl(dpCtrl), .sdaOe(sdaOe), .stateOut(ctlState)
  );

  i2cs_datapath #(.NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit), .hsMode(hsMode),
    .ptr(ptr), .regFlat(regFlat)
  );

endmodule

// File: rtl/hs_i2c_regbank_chk.sv
module hs_i2c_regbank_chk
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclLvl,
  input logic                  startDet,
  input logic                  stopDet,
  input logic                  sdaOe,
  input logic                  hsMode,
  input busState_t             state,
  input logic                  regWrite,
  input logic [7:0]            ptr,
  input logic [NUM_REGS*8-1:0] regFlat
);

  // R1: a STOP releases the bus and returns to idle
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaOe && state == ST_IDLE));

  // R2: the SDA drive only moves while SCL is low (outside START/STOP handling)
  assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet) && !$past(stopDet)) |-> !sclLvl);

  // R4: entering HS mode never comes with an acknowledge
  assert_hs_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> (state == ST_WAIT && !sdaOe));

  // R8: only a STOP can clear HS mode, a repeated START keeps it
  assert_hs_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && !stopDet) |=> hsMode);

  // R7: writes outside the map leave every register unchanged
  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && ({1'b0, ptr} >= 9'(NUM_REGS))) |=> $stable(regFlat));

endmodule

bind hs_i2c_regbank hs_i2c_regbank_chk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .hsMode(hsMode), .state(ctlState),
  .regWrite(dpCtrl.regWrite), .ptr(ptr), .regFlat(regFlat)
);

// File: tb/hs_i2c_regbank_test.sv
`timescale 1ns/1ps
module hs_i2c_regbank_test;

  localparam int NREG = 4;
  localparam int Q    = 5;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdaOe, hsMode;
  logic [NREG*8-1:0] regFlat;
  logic sdaBus;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [7:0] expRegs [NREG];

  assign sdaBus = sdaM & ~sdaOe;

  always #10 clk = ~clk;

  hs_i2c_regbank #(.NUM_REGS(NREG)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .strapAddr(strap), .sdaOe(sdaOe), .hsMode(hsMode), .regFlat(regFlat)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    waitCyc(Q); sdaM = 1'b0; waitCyc(HALF); scl = 1'b0;
  endtask

  task automatic busRestart();
    waitCyc(Q); sdaM = 1'b1; waitCyc(Q); scl = 1'b1;
    waitCyc(HALF); sdaM = 1'b0; waitCyc(HALF); scl = 1'b0;
  endtask

  task automatic busStop();
    waitCyc(Q); sdaM = 1'b0; waitCyc(Q); scl = 1'b1;
    waitCyc(HALF); sdaM = 1'b1; waitCyc(HALF);
  endtask

  task automatic writeBit(input logic b);
    waitCyc(Q); sdaM = b; waitCyc(Q); scl = 1'b1; waitCyc(HALF); scl = 1'b0;
  endtask

  task automatic readBit(output logic v);
    waitCyc(Q); sdaM = 1'b1; waitCyc(Q); scl = 1'b1;
    waitCyc(Q); v = sdaBus; waitCyc(Q); scl = 1'b0;
  endtask

  // ack counts only if SDA is low for every sample of the high phase
  task automatic readAck(output logic heldLow);
    waitCyc(Q); sdaM = 1'b1; waitCyc(Q); scl = 1'b1;
    heldLow = 1'b1;
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      if (sdaBus) heldLow = 1'b0;
    end
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    readAck(ack);
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      readBit(v);
      b[i] = v;
    end
    writeBit(mAck ? 1'b0 : 1'b1);
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < NREG; i++)
      check(regFlat[i*8 +: 8] == expRegs[i], req, regFlat[i*8 +: 8], expRegs[i]);
  endtask

  task automatic testReset();
    check(sdaOe == 1'b0, "R9 sdaOe", sdaOe, 0);
    check(hsMode == 1'b0, "R9 hsMode", hsMode, 0);
    checkRegs("R9 regs");
  endtask

  task automatic testWrite();
    logic ack;
    busStart();
    sendByte(8'h94, ack); check(ack, "R2 own address ack", ack, 1);
    sendByte(8'h01, ack); check(ack, "R5 pointer ack", ack, 1);
    sendByte(8'hA5, ack); check(ack, "R5 data ack", ack, 1);
    sendByte(8'h3C, ack); check(ack, "R5 data ack", ack, 1);
    busStop();
    expRegs[1] = 8'hA5; expRegs[2] = 8'h3C;
    checkRegs("R5 write autoinc");
    check(sdaOe == 1'b0, "R1 released after stop", sdaOe, 0);
  endtask

  task automatic testRead();
    logic ack, v;
    logic [7:0] b;
    busStart();
    sendByte(8'h94, ack);
    sendByte(8'h01, ack);
    busRestart();
    sendByte(8'h95, ack); check(ack, "R8 restart read address ack", ack, 1);
    recvByte(1'b1, b); check(b == 8'hA5, "R6 read byte0", b, 8'hA5);
    recvByte(1'b1, b); check(b == 8'h3C, "R6 read byte1", b, 8'h3C);
    recvByte(1'b0, b); check(b == 8'h00, "R6 read byte2", b, 8'h00);
    readBit(v); check(v == 1'b1, "R6 released after nack", v, 1);
    busStop();
  endtask

  task automatic testUnmapped();
    logic ack;
    logic [7:0] b;
    busStart();
    sendByte(8'h94, ack);
    sendByte(8'h03, ack);
    sendByte(8'h11, ack);
    sendByte(8'h22, ack); check(ack, "R5 ack beyond map", ack, 1);
    busStop();
    expRegs[3] = 8'h11;
    checkRegs("R7 unmapped write ignored");
    busStart();
    sendByte(8'h94, ack);
    sendByte(8'h03, ack);
    busRestart();
    sendByte(8'h95, ack);
    recvByte(1'b1, b); check(b == 8'h11, "R7 last mapped", b, 8'h11);
    recvByte(1'b0, b); check(b == 8'hFF, "R7 past end reads FF", b, 8'hFF);
    busStop();
    busStart();
    sendByte(8'h94, ack);
    sendByte(8'h7F, ack);
    busRestart();
    sendByte(8'h95, ack);
    recvByte(1'b0, b); check(b == 8'hFF, "R7 far pointer reads FF", b, 8'hFF);
    busStop();
  endtask

  task automatic testForeign();
    logic ack;
    busStart();
    sendByte(8'h96, ack); check(!ack, "R2 strap mismatch nack", ack, 0);
    sendByte(8'h00, ack);
    sendByte(8'h77, ack); check(!ack, "R2 foreign data nack", ack, 0);
    busStop();
    busStart();
    sendByte(8'h24, ack); check(!ack, "R2 prefix mismatch nack", ack, 0);
    busStop();
    busStart();
    sendByte(8'h00, ack); check(!ack, "R3 general call nack", ack, 0);
    sendByte(8'h00, ack);
    sendByte(8'h99, ack); check(!ack, "R3 general call data nack", ack, 0);
    busStop();
    checkRegs("R3 no register change");
    check(hsMode == 1'b0, "R4 hsMode stays clear", hsMode, 0);
  endtask

  task automatic testHsMode();
    logic ack;
    busStart();
    sendByte(8'h0B, ack); check(!ack, "R4 hs code nack", ack, 0);
    check(hsMode == 1'b1, "R4 hsMode set", hsMode, 1);
    busRestart();
    check(hsMode == 1'b1, "R8 hsMode kept on restart", hsMode, 1);
    sendByte(8'h94, ack); check(ack, "R8 address after hs code", ack, 1);
    sendByte(8'h00, ack);
    sendByte(8'h5A, ack);
    check(hsMode == 1'b1, "R4 hsMode held in transfer", hsMode, 1);
    busStop();
    waitCyc(4);
    check(hsMode == 1'b0, "R4 hsMode cleared by stop", hsMode, 0);
    expRegs[0] = 8'h5A;
    checkRegs("R4 write in hs mode");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) expRegs[i] = 8'h00;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    testReset();
    testWrite();
    testRead();
    testUnmapped();
    testForeign();
    testHsMode();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule